// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the 256-byte configuration space of a type-0 PCI function and serves it through a simple byte-addressed port. Each request carries an offset, a length of 1 to 4 bytes and up to four data bytes, little-endian. The response comes one cycle later. Below offset 0x40 every byte has a fixed set of writable bits. One status byte clears bits when software writes ones to them. From offset 0x40 upward, bytes are stored exactly as written.

Apart from storage, the block handles the side effects that software relies on:
- Two 64-bit memory BARs answer a size probe with their size mask.
- The remaining BARs read back zero after a probe.
- The expansion ROM register reports that no ROM is present.
- Two decode-enable outputs, one per implemented BAR, follow the memory-enable bit of the command register and are dropped while a BAR is being probed or moved.
- A sticky flag records that the function was put into the D3hot power state.
- Illegal requests are answered with an error flag and change nothing.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: After reset, the image reads as follows:
  - Bytes 0x00-0x03 read ABCD/0123 as vendor/device (little-endian bytes CD AB 23 01).
  - The command byte 0x04 reads 0x00 and byte 0x05 reads 0x04. Status reads 0x10 at 0x06 and 0xB6 at 0x07.
  - BAR0 (0x10) reads 0xE0000004 and BAR2 (0x18) reads 0xC000000C. BAR1 (0x14), BAR3, BAR4, BAR5 and the ROM register (0x30) read zero.
  - The capability pointer 0x34 reads 0x40. The power capability sits at 0x40 (ID 0x01, capability word 0x0003), and its control/status register is at 0x44 and reads zero.
  - Both decode enables and the D3 flag are low.
- R2: Every request is answered in the following cycle.
  - A legal read returns the addressed bytes with offset+i on bits 8i+7:8i. Bytes beyond the length read zero.
  - Writes return zero data.
- R3: A write to a byte below 0x40 changes only the bits set in that byte's mask. All other bytes below 0x40 are read-only. The masks are:

  | Byte offset | Mask |
  |---|---|
  | 0x04 | 0xFF |
  | 0x05 | 0x07 |
  | 0x06 | 0x00 |
  | 0x07 | 0xF9 |
  | 0x0C | 0xFF |
  | 0x10-0x27 | 0xFF |
  | 0x30 | 0x01 |
  | 0x31 | 0xF8 |
  | 0x32 | 0xFF |
  | 0x33 | 0xFF |
  | 0x3C | 0xFF |

- R4: At byte 0x07, a 1 written to a masked bit clears that bit, and a 0 leaves it unchanged.
- R5: Bytes at 0x40 and above take the written value unmasked.
- R6: A request is rejected in any of these cases:
  - The length is 0 or greater than 4.
  - offset+length exceeds 256.
  - It is a write at offset 0x04 longer than 2 bytes.
  - It is a write at an offset that is not 4-byte aligned inside the BAR range 0x10-0x27 or the ROM dword 0x30-0x33.

  A rejected request returns the error flag with zero data and changes neither storage nor any output.
- R7: A write of 0xFFFFFFFF to a BAR is a size probe. It stores the complement of (size-1), with the lower 32 bits going to the even BAR and the upper 32 bits to the odd BAR:

  | BAR | Size | Lower half | Upper half |
  |---|---|---|---|
  | BAR0/BAR1 | 16 MiB | 0xFF000000 | 0xFFFFFFFF |
  | BAR2/BAR3 | 256 MiB | 0xF0000000 | 0xFFFFFFFF |

  A probe of BAR4 or BAR5 stores zero. A probe clears the decode enable of BAR0/1 (first output) or BAR2/3 (second output).
- R8: Any other write to a BAR stores the full 32-bit data word, whatever the length. For BAR0-BAR3, it sets that BAR's decode enable to the current memory-enable bit (bit 1 of byte 0x04).
- R9: A write to 0x30 whose data has all of bits 31:11 set clears the whole ROM dword to zero. Any other write there follows the R3 masks.
- R10: A write at offset 0x04 whose byte-0 bit 1 differs from the stored bit changes both decode enables: both go high when the bit rises and both go low when it falls.
- R11: A write at offset 0x44 with data bits 1:0 equal to 3 sets the D3 flag. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 8 | Byte offset of the first byte |
| req_len | input | 3 | Number of bytes, 1 to 4 legal |
| req_wdata | input | 32 | Write data, first byte in bits 7:0 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| mmio_dec_en | output | 1 | Decode enable for BAR0/BAR1 |
| aper_dec_en | output | 1 | Decode enable for BAR2/BAR3 |
| d3_entered | output | 1 | Sticky D3hot entry flag |

## Verification
A wrong byte in storage stays hidden until a read covers it. The bench therefore reads back constantly at random offsets, and a corrupted mask, RW1C merge or probe value shows in the response of the next read of that byte, one cycle after the request. A stale decode enable shows at the output pins in the cycle right after the command or BAR write that should have moved it. Errors in the access checker show up as a wrong error flag on the very response of the illegal request, and as changed data on the next read if a rejected write leaked into storage.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int unsigned STD_HDR_END = 64;
  localparam int unsigned CMD_OFF     = 4;
  localparam int unsigned STAT_HI_OFF = 7;
  localparam int unsigned BAR_FIRST   = 16;
  localparam int unsigned BAR_COUNT   = 6;
  localparam int unsigned ROM_OFF     = 48;
  localparam int unsigned CAP_PTR_OFF = 52;
  localparam logic [31:0] ROM_ADDR_MASK = 32'hFFFF_F800;
  localparam logic [7:0]  CMD_RESET_CLR = 8'h07;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_CMD   = 2'd1,
    ACC_BAR   = 2'd2,
    ACC_ROM   = 2'd3
  } acc_kind_e;

  // Writable bits of each byte inside the standard header.
  function automatic logic [7:0] wr_mask(int unsigned a);
    logic [7:0] m;
    m = 8'h00;
    if (a >= BAR_FIRST && a < BAR_FIRST + 4 * BAR_COUNT) m = 8'hFF;
    case (a)
      4, 12, 60:          m = 8'hFF;
      5:                  m = 8'h07;
      7:                  m = 8'hF9;
      48:                 m = 8'h01;
      49:                 m = 8'hF8;
      50, 51:             m = 8'hFF;
      default:            ;
    endcase
    return m;
  endfunction

  // Byte update rule: masked, write-one-to-clear, or unmasked above the header.
  function automatic logic [7:0] merge_byte(int unsigned a, logic [7:0] old_b,
                                            logic [7:0] din);
    logic [7:0] m;
    if (a >= STD_HDR_END) return din;
    m = wr_mask(a);
    if (a == STAT_HI_OFF) return old_b & ~(din & m);
    return (old_b & ~m) | (din & m);
  endfunction

  // Image before the reset clean-up.
  function automatic logic [7:0] raw_byte(int unsigned a, logic [15:0] vid,
                                          logic [15:0] did, logic [31:0] b0,
                                          logic [31:0] b2, logic [7:0] cap);
    logic [7:0] r;
    r = 8'h00;
    if (a == int'(cap))          r = 8'h01;
    else if (a == int'(cap) + 2) r = 8'h03;
    case (a)
      0:  r = vid[7:0];
      1:  r = vid[15:8];
      2:  r = did[7:0];
      3:  r = did[15:8];
      4:  r = 8'h07;
      5:  r = 8'h04;
      6:  r = 8'h10;
      7:  r = 8'hB6;
      8:  r = 8'h01;
      11: r = 8'h03;
      16: r = b0[7:0];
      17: r = b0[15:8];
      18: r = b0[23:16];
      19: r = b0[31:24];
      20: r = 8'h5A;
      24: r = b2[7:0];
      25: r = b2[15:8];
      26: r = b2[23:16];
      27: r = b2[31:24];
      28: r = 8'h01;
      32: r = 8'h33;
      36: r = 8'h44;
      44: r = vid[7:0];
      45: r = vid[15:8];
      46: r = 8'h01;
      48: r = 8'h01;
      50: r = 8'h0E;
      52: r = cap;
      61: r = 8'h01;
      default: ;
    endcase
    return r;
  endfunction

  // Reset clean-up: enables off, upper BAR halves, spare BARs and ROM cleared.
  function automatic logic [7:0] clear_byte(int unsigned a, logic [7:0] v);
    if (a == CMD_OFF) return v & ~CMD_RESET_CLR;
    if (a >= 20 && a < 24) return 8'h00;
    if (a >= 28 && a < 40) return 8'h00;
    if (a >= ROM_OFF && a < ROM_OFF + 4) return 8'h00;
    return v;
  endfunction

  function automatic logic [7:0] reset_byte(int unsigned a, logic [15:0] vid,
                                            logic [15:0] did, logic [31:0] b0,
                                            logic [31:0] b2, logic [7:0] cap);
    return clear_byte(a, raw_byte(a, vid, did, b0, b2, cap));
  endfunction

  // Size probe answer: one half of ~(size-1).
  function automatic logic [31:0] probe_word(logic [63:0] size, logic upper);
    logic [63:0] inv;
    inv = ~(size - 64'd1);
    return upper ? inv[63:32] : inv[31:0];
  endfunction

endpackage

// File: rtl/cfg_hdr_access_check.sv
module cfg_hdr_access_check
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LEN_W     = 3,
  parameter int unsigned CFG_BYTES = 256,
  parameter int unsigned ACC_BYTES = 4
) (
  input  logic [ADDR_W-1:0] off_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              write_i,
  output logic              err_o,
  output acc_kind_e         kind_o,
  output logic [2:0]        bar_idx_o
);

  logic [ADDR_W:0] end_pos;
  logic            in_bar;
  logic            in_rom;
  logic            bad_len;
  logic            past_end;
  logic            cmd_too_long;
  logic            misaligned;

  always_comb begin
    end_pos  = {1'b0, off_i} + (ADDR_W+1)'(len_i);
    in_bar   = (off_i >= ADDR_W'(BAR_FIRST)) &&
               (off_i <  ADDR_W'(BAR_FIRST + 4 * BAR_COUNT));
    in_rom   = (off_i >= ADDR_W'(ROM_OFF)) && (off_i < ADDR_W'(ROM_OFF + 4));
    if (off_i == ADDR_W'(CMD_OFF)) kind_o = ACC_CMD;
    else if (in_bar)               kind_o = ACC_BAR;
    else if (in_rom)               kind_o = ACC_ROM;
    else                           kind_o = ACC_PLAIN;
    bar_idx_o    = 3'((off_i - ADDR_W'(BAR_FIRST)) >> 2);
    bad_len      = (len_i == '0) || (len_i > LEN_W'(ACC_BYTES));
    past_end     = end_pos > (ADDR_W+1)'(CFG_BYTES);
    cmd_too_long = write_i && (kind_o == ACC_CMD) && (len_i > LEN_W'(2));
    misaligned   = write_i && (kind_o == ACC_BAR || kind_o == ACC_ROM) &&
                   (off_i[1:0] != 2'b00);
    err_o        = bad_len || past_end || cmd_too_long || misaligned;
  end

endmodule

// File: rtl/cfg_hdr_lane.sv
module cfg_hdr_lane
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        old_i,
  input  logic [7:0]        din_i,
  input  logic              force_en_i,
  input  logic [7:0]        force_i,
  output logic [7:0]        new_o
);

  assign new_o = force_en_i ? force_i : merge_byte(int'(addr_i), old_i, din_i);

endmodule

// File: rtl/cfg_hdr_decode_ctl.sv
module cfg_hdr_decode_ctl
  import cfg_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok_i,
  input  acc_kind_e  kind_i,
  input  logic [2:0] bar_idx_i,
  input  logic       probe_i,
  input  logic       mem_en_i,
  input  logic [7:0] cmd_new_i,
  input  logic       pm_hit_i,
  output logic       mmio_dec_o,
  output logic       aper_dec_o,
  output logic       d3_o,
  output logic       ev_rise_o,
  output logic       ev_fall_o,
  output logic       ev_probe_mmio_o,
  output logic       ev_probe_aper_o
);

  logic bar_mmio_wr;
  logic bar_aper_wr;

  assign ev_rise_o       = wr_ok_i && (kind_i == ACC_CMD) && !mem_en_i && cmd_new_i[1];
  assign ev_fall_o       = wr_ok_i && (kind_i == ACC_CMD) && mem_en_i && !cmd_new_i[1];
  assign bar_mmio_wr     = wr_ok_i && (kind_i == ACC_BAR) && (bar_idx_i < 3'd2);
  assign bar_aper_wr     = wr_ok_i && (kind_i == ACC_BAR) &&
                           (bar_idx_i == 3'd2 || bar_idx_i == 3'd3);
  assign ev_probe_mmio_o = bar_mmio_wr && probe_i;
  assign ev_probe_aper_o = bar_aper_wr && probe_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmio_dec_o <= 1'b0;
      aper_dec_o <= 1'b0;
      d3_o       <= 1'b0;
    end else begin
      if (ev_rise_o) begin
        mmio_dec_o <= 1'b1;
        aper_dec_o <= 1'b1;
      end else if (ev_fall_o) begin
        mmio_dec_o <= 1'b0;
        aper_dec_o <= 1'b0;
      end
      if (bar_mmio_wr) mmio_dec_o <= probe_i ? 1'b0 : mem_en_i;
      if (bar_aper_wr) aper_dec_o <= probe_i ? 1'b0 : mem_en_i;
      if (pm_hit_i)    d3_o       <= 1'b1;
    end
  end

endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned CFG_BYTES  = 256,
  parameter int unsigned ACC_BYTES  = 4,
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h0123,
  parameter logic [31:0] BAR0_BASE  = 32'hE000_0004,
  parameter logic [31:0] BAR2_BASE  = 32'hC000_000C,
  parameter logic [63:0] BAR0_SIZE  = 64'h0000_0000_0100_0000,
  parameter logic [63:0] BAR2_SIZE  = 64'h0000_0000_1000_0000,
  parameter logic [7:0]  PM_CAP_OFF = 8'h40,
  localparam int unsigned ADDR_W    = $clog2(CFG_BYTES),
  localparam int unsigned LEN_W     = $clog2(ACC_BYTES) + 1,
  localparam int unsigned DATA_W    = 8 * ACC_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mmio_dec_en,
  output logic              aper_dec_en,
  output logic              d3_entered
);

  localparam logic [ADDR_W-1:0] PMCSR_OFF = ADDR_W'(int'(PM_CAP_OFF) + 4);

  logic [7:0]        cfg_mem [CFG_BYTES];

  logic              acc_err;
  acc_kind_e         acc_kind;
  logic [2:0]        bar_idx;
  logic              wr_ok;
  logic              bar_probe;
  logic              rom_probe;
  logic              force_dword;
  logic [DATA_W-1:0] probe_val;
  logic [DATA_W-1:0] dword_val;
  logic              pm_hit;
  logic [DATA_W-1:0] rd_word;

  // Named internal events for the checker.
  logic              ev_cmd_rise;
  logic              ev_cmd_fall;
  logic              ev_probe_mmio;
  logic              ev_probe_aper;

  logic [ADDR_W-1:0] lane_addr [ACC_BYTES];
  logic [7:0]        lane_new  [ACC_BYTES];
  logic              lane_we   [ACC_BYTES];

  cfg_hdr_access_check #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .CFG_BYTES(CFG_BYTES),
    .ACC_BYTES(ACC_BYTES)
  ) u_check (
    .off_i    (req_off),
    .len_i    (req_len),
    .write_i  (req_write),
    .err_o    (acc_err),
    .kind_o   (acc_kind),
    .bar_idx_o(bar_idx)
  );

  assign wr_ok     = req_valid && req_write && !acc_err;
  assign bar_probe = &req_wdata;
  assign rom_probe = (req_wdata & DATA_W'(ROM_ADDR_MASK)) == DATA_W'(ROM_ADDR_MASK);

  always_comb begin
    case (bar_idx)
      3'd0:    probe_val = DATA_W'(probe_word(BAR0_SIZE, 1'b0));
      3'd1:    probe_val = DATA_W'(probe_word(BAR0_SIZE, 1'b1));
      3'd2:    probe_val = DATA_W'(probe_word(BAR2_SIZE, 1'b0));
      3'd3:    probe_val = DATA_W'(probe_word(BAR2_SIZE, 1'b1));
      default: probe_val = '0;
    endcase
  end

  always_comb begin
    force_dword = 1'b0;
    dword_val   = '0;
    if (acc_kind == ACC_BAR) begin
      force_dword = 1'b1;
      dword_val   = bar_probe ? probe_val : req_wdata;
    end else if (acc_kind == ACC_ROM && rom_probe) begin
      force_dword = 1'b1;
    end
  end

  assign pm_hit = wr_ok && (acc_kind == ACC_PLAIN) && (req_off == PMCSR_OFF) &&
                  (req_wdata[1:0] == 2'b11);

  for (genvar g = 0; g < ACC_BYTES; g++) begin : g_lane
    assign lane_addr[g] = req_off + ADDR_W'(g);
    assign lane_we[g]   = wr_ok && (force_dword || (g < int'(req_len)));

    cfg_hdr_lane #(.ADDR_W(ADDR_W)) u_lane (
      .addr_i    (lane_addr[g]),
      .old_i     (cfg_mem[lane_addr[g]]),
      .din_i     (req_wdata[8*g +: 8]),
      .force_en_i(force_dword),
      .force_i   (dword_val[8*g +: 8]),
      .new_o     (lane_new[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < CFG_BYTES; j++) begin
        cfg_mem[j] <= reset_byte(j, VENDOR_ID, DEVICE_ID, BAR0_BASE, BAR2_BASE,
                                 PM_CAP_OFF);
      end
    end else begin
      for (int i = 0; i < ACC_BYTES; i++) begin
        if (lane_we[i]) cfg_mem[lane_addr[i]] <= lane_new[i];
      end
    end
  end

  cfg_hdr_decode_ctl u_dec (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_ok_i        (wr_ok),
    .kind_i         (acc_kind),
    .bar_idx_i      (bar_idx),
    .probe_i        (bar_probe),
    .mem_en_i       (cfg_mem[CMD_OFF][1]),
    .cmd_new_i      (req_wdata[7:0]),
    .pm_hit_i       (pm_hit),
    .mmio_dec_o     (mmio_dec_en),
    .aper_dec_o     (aper_dec_en),
    .d3_o           (d3_entered),
    .ev_rise_o      (ev_cmd_rise),
    .ev_fall_o      (ev_cmd_fall),
    .ev_probe_mmio_o(ev_probe_mmio),
    .ev_probe_aper_o(ev_probe_aper)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < ACC_BYTES; i++) begin
      if (i < int'(req_len) && (int'(req_off) + i) < CFG_BYTES)
        rd_word[8*i +: 8] = cfg_mem[ADDR_W'(int'(req_off) + i)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && acc_err;
      rsp_rdata <= (req_valid && !req_write && !acc_err) ? rd_word : '0;
    end
  end

endmodule

// File: rtl/cfg_hdr_checker.sv
module cfg_hdr_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_err,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mmio_dec_en,
  input logic              aper_dec_en,
  input logic              d3_entered,
  input logic              ev_cmd_rise,
  input logic              ev_cmd_fall,
  input logic              ev_probe_mmio,
  input logic              ev_probe_aper
);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_err_data_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  assert_reject_keeps_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_err) |=> ($stable(mmio_dec_en) && $stable(aper_dec_en) &&
                                $stable(d3_entered)));

  assert_probe_mmio_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_probe_mmio |=> !mmio_dec_en);

  assert_probe_aper_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_probe_aper |=> !aper_dec_en);

  assert_mem_rise_enables_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_rise |=> (mmio_dec_en && aper_dec_en));

  assert_mem_fall_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_fall |=> (!mmio_dec_en && !aper_dec_en));

  assert_d3_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    d3_entered |=> d3_entered);

endmodule

bind cfg_hdr_regfile cfg_hdr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_err      (acc_err),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_rdata    (rsp_rdata),
  .mmio_dec_en  (mmio_dec_en),
  .aper_dec_en  (aper_dec_en),
  .d3_entered   (d3_entered),
  .ev_cmd_rise  (ev_cmd_rise),
  .ev_cmd_fall  (ev_cmd_fall),
  .ev_probe_mmio(ev_probe_mmio),
  .ev_probe_aper(ev_probe_aper)
);

// File: tb/cfg_hdr_regfile_tb_top.sv
`timescale 1ns/1ps
module cfg_hdr_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_off = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        mmio_dec_en;
  logic        aper_dec_en;
  logic        d3_entered;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m [256];
  bit exp_mmio, exp_aper, exp_d3;

  always #2.5 clk = ~clk;

  cfg_hdr_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mmio_dec_en(mmio_dec_en), .aper_dec_en(aper_dec_en), .d3_entered(d3_entered)
  );

  function automatic logic [7:0] img(int a);
    case (a)
      0: return 8'hCD;  1: return 8'hAB;  2: return 8'h23;  3: return 8'h01;
      5: return 8'h04;  6: return 8'h10;  7: return 8'hB6;  8: return 8'h01;
      11: return 8'h03; 16: return 8'h04; 19: return 8'hE0; 24: return 8'h0C;
      27: return 8'hC0; 44: return 8'hCD; 45: return 8'hAB; 46: return 8'h01;
      52: return 8'h40; 61: return 8'h01; 64: return 8'h01; 66: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bmask(int a);
    if (a >= 16 && a <= 39) return 8'hFF;
    case (a)
      4, 12, 50, 51, 60: return 8'hFF;
      5:  return 8'h07;
      7:  return 8'hF9;
      48: return 8'h01;
      49: return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit m_err(bit w, int off, int len);
    if (len < 1 || len > 4) return 1;
    if (off + len > 256) return 1;
    if (w && off == 4 && len > 2) return 1;
    if (w && ((off >= 16 && off < 40) || (off >= 48 && off < 52)) && (off % 4) != 0)
      return 1;
    return 0;
  endfunction

  task automatic put_bytes(int off, int len, logic [31:0] d);
    for (int i = 0; i < len; i++) begin
      int a = off + i;
      logic [7:0] b = d[8*i +: 8];
      if (a >= 64) m[a] = b;
      else if (a == 7) m[a] = m[a] & ~(b & bmask(a));
      else m[a] = (m[a] & ~bmask(a)) | (b & bmask(a));
    end
  endtask

  task automatic put_dword(int off, logic [31:0] v);
    for (int i = 0; i < 4; i++) m[off + i] = v[8*i +: 8];
  endtask

  task automatic m_write(int off, int len, logic [31:0] d);
    if (off == 4) begin
      logic [7:0] old = m[4];
      put_bytes(off, len, d);
      if (old[1] != d[1]) begin
        exp_mmio = !old[1];
        exp_aper = !old[1];
      end
    end else if (off >= 16 && off < 40) begin
      int idx = (off - 16) / 4;
      if (d == 32'hFFFF_FFFF) begin
        case (idx)
          0: put_dword(off, 32'hFF00_0000);
          1: put_dword(off, 32'hFFFF_FFFF);
          2: put_dword(off, 32'hF000_0000);
          3: put_dword(off, 32'hFFFF_FFFF);
          default: put_dword(off, 32'h0);
        endcase
        if (idx < 2) exp_mmio = 0;
        else if (idx < 4) exp_aper = 0;
      end else begin
        put_dword(off, d);
        if (idx < 2) exp_mmio = m[4][1];
        else if (idx < 4) exp_aper = m[4][1];
      end
    end else if (off == 48 && d[31:11] == 21'h1F_FFFF) begin
      put_dword(48, 32'h0);
    end else begin
      put_bytes(off, len, d);
      if (off == 68 && d[1:0] == 2'b11) exp_d3 = 1;
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic access(bit w, int off, int len, logic [31:0] d, string tag);
    bit e;
    logic [31:0] er;
    e  = m_err(w, off, len);
    er = '0;
    if (!w && !e) for (int i = 0; i < len; i++) er[8*i +: 8] = m[off + i];
    @(negedge clk);
    req_valid = 1; req_write = w; req_off = off[7:0]; req_len = len[2:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (w && !e) m_write(off, len, d);
    check(rsp_valid === 1'b1, tag, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(rsp_err === e, tag, "rsp_err", {31'b0, rsp_err}, {31'b0, e});
    check(rsp_rdata === er, tag, "rsp_rdata", rsp_rdata, er);
    check(mmio_dec_en === exp_mmio, tag, "mmio_dec_en", {31'b0, mmio_dec_en}, {31'b0, exp_mmio});
    check(aper_dec_en === exp_aper, tag, "aper_dec_en", {31'b0, aper_dec_en}, {31'b0, exp_aper});
    check(d3_entered === exp_d3, tag, "d3_entered", {31'b0, d3_entered}, {31'b0, exp_d3});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) m[a] = img(a);
    exp_mmio = 0; exp_aper = 0; exp_d3 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset image and outputs
    check(mmio_dec_en === 1'b0 && aper_dec_en === 1'b0 && d3_entered === 1'b0,
          "R1", "outputs", {29'b0, mmio_dec_en, aper_dec_en, d3_entered}, 32'h0);
    check(rsp_valid === 1'b0, "R1", "rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
    access(0, 0,  4, 0, "R1 ids");
    access(0, 4,  4, 0, "R1 cmd/status");
    access(0, 16, 4, 0, "R1 bar0");
    access(0, 20, 4, 0, "R1 bar1");
    access(0, 24, 4, 0, "R1 bar2");
    access(0, 48, 4, 0, "R1 rom");
    access(0, 52, 1, 0, "R1 cap ptr");
    access(0, 64, 4, 0, "R1 pm cap");
    // R2: partial and unaligned reads
    access(0, 0,  3, 0, "R2 three bytes");
    access(0, 61, 1, 0, "R2 one byte");
    access(0, 62, 4, 0, "R2 crossing");
    // R3: masks
    access(1, 4,  2, 32'h0000_FFF8, "R3 cmd mask");
    access(1, 8,  4, 32'hFFFF_FFFF, "R3 read-only");
    access(1, 12, 1, 32'h0000_0040, "R3 cache line");
    access(1, 60, 2, 32'h0000_FFAA, "R3 int line/pin");
    access(0, 4,  4, 0, "R3 readback");
    access(0, 8,  4, 0, "R3 readback ro");
    access(0, 60, 4, 0, "R3 readback int");
    // R4: write-one-to-clear
    access(1, 6,  2, 32'h0000_10FF, "R4 clear bit4");
    access(1, 7,  1, 32'h0000_0006, "R4 masked ones");
    access(0, 6,  2, 0, "R4 readback");
    access(1, 7,  1, 32'h0000_00FF, "R4 clear all");
    access(0, 7,  1, 0, "R4 readback all");
    // R5: unmasked
    access(1, 72, 4, 32'hDEAD_BEEF, "R5 dword");
    access(1, 254, 2, 32'h0000_5AA5, "R5 last bytes");
    access(0, 72, 4, 0, "R5 readback");
    access(0, 254, 2, 0, "R5 readback end");
    // R6: rejected requests
    access(0, 0,  0, 0, "R6 len0");
    access(1, 72, 5, 32'h1111_1111, "R6 len5");
    access(0, 253, 4, 0, "R6 past end");
    access(1, 255, 2, 32'h0000_FFFF, "R6 write past end");
    access(1, 4,  3, 32'h0000_0002, "R6 cmd len3");
    access(1, 17, 1, 32'h0000_0077, "R6 bar misaligned");
    access(1, 50, 2, 32'h0000_0000, "R6 rom misaligned");
    access(0, 72, 4, 0, "R6 unchanged");
    access(0, 16, 4, 0, "R6 bar unchanged");
    // R10 then R8: memory enable and BAR moves
    access(1, 4,  1, 32'h0000_0002, "R10 rise");
    access(1, 16, 4, 32'h1234_0004, "R8 bar0 move enabled");
    access(0, 16, 4, 0, "R8 bar0 readback");
    // R7: probes
    access(1, 16, 4, 32'hFFFF_FFFF, "R7 probe bar0");
    access(1, 20, 4, 32'hFFFF_FFFF, "R7 probe bar1");
    access(1, 24, 4, 32'hFFFF_FFFF, "R7 probe bar2");
    access(1, 28, 4, 32'hFFFF_FFFF, "R7 probe bar3");
    access(1, 32, 4, 32'hFFFF_FFFF, "R7 probe bar4");
    access(0, 16, 4, 0, "R7 bar0 mask");
    access(0, 20, 4, 0, "R7 bar1 mask");
    access(0, 24, 4, 0, "R7 bar2 mask");
    access(0, 28, 4, 0, "R7 bar3 mask");
    access(0, 32, 4, 0, "R7 bar4 zero");
    access(1, 24, 2, 32'hAB00_000C, "R8 short bar2 write");
    access(0, 24, 4, 0, "R8 full dword stored");
    access(1, 36, 4, 32'h0F0F_0000, "R8 bar5 plain");
    access(1, 4,  1, 32'h0000_0000, "R10 fall");
    access(1, 20, 4, 32'h0000_0001, "R8 bar1 mem off");
    access(1, 4,  1, 32'h0000_0002, "R10 rise again");
    access(1, 4,  1, 32'h0000_0006, "R10 no toggle");
    // R9: ROM
    access(1, 48, 4, 32'h1234_5601, "R9 masked");
    access(0, 48, 4, 0, "R9 masked readback");
    access(1, 48, 4, 32'hFFFF_F801, "R9 probe");
    access(0, 48, 4, 0, "R9 probe readback");
    // R11: power state
    access(1, 68, 2, 32'h0000_0002, "R11 D2 only");
    access(1, 68, 2, 32'h0000_0003, "R11 D3hot");
    access(1, 68, 2, 32'h0000_0000, "R11 sticky");
    access(0, 68, 2, 0, "R11 readback");
    // Random mix; tags name the requirements the model covers.
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      int off;
      int len;
      bit w;
      logic [31:0] d;
      off = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 79);
      len = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7) : $urandom_range(1, 4);
      w   = $urandom_range(0, 2) == 0;
      d   = ($urandom_range(0, 15) == 0) ? 32'hFFFF_FFFF : $urandom;
      if (w) access(1, off, len, d, "R3 R6 R8 random write");
      else   access(0, off, len, 0, "R2 R6 random read");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule